// File: doc/BRIEF.md
# Transmit Byte Queue with Underrun Abort

This block sits between the side that fetches frame bytes from memory and the serial transmitter that consumes them. It holds up to three bytes, each tagged with an end-of-frame flag. It passes them to the transmitter in the order they were written.

When the transmitter asks for a byte in the middle of a frame and the queue is empty, the block treats this as an underrun. It does the following:

- abandons the frame and discards whatever the queue holds;
- reports the buffer as closed with its underrun status bit set;
- raises a one-cycle error interrupt, if the interrupt is enabled.

From then on it refuses all traffic on both sides until a restart command arrives.

Both data sides are valid/ready streams. On the write side, a byte is taken on a rising edge where `wr_valid` and `wr_ready` are both high. The writer must hold `wr_valid`, `wr_byte` and `wr_eof` steady while `wr_ready` is low. On the transmit side, a byte moves on an edge where `tx_valid` and `tx_ready` are both high. `tx_ready` high means the transmitter needs a byte now; this is the signal that turns an empty queue into an underrun. The interrupt enable and the restart command are plain level and pulse inputs. The close, underrun and interrupt outputs are plain status pins.

Top module: `txq_abort_top`

## Requirements
- R1: The queue holds up to three bytes. `wr_ready` is low while three bytes are held, and bytes leave on `tx_byte` in the order they were accepted, each with its `tx_eof` flag.
- R2: `tx_valid` is high whenever the queue is non-empty and the block is not halted. A write and a read in the same cycle keep a continuous stream flowing without a gap.
- R3: A frame is open from the transfer of its first byte until the transfer of a byte with `tx_eof`=1. A byte carrying `tx_eof`=1 as the first byte never opens a frame. An empty queue with `tx_ready` high while no frame is open causes no close, no halt and no interrupt.
- R4: Underrun means `tx_ready` is high, the queue is empty, a frame is open and the block is not halted. In the cycle after an underrun, `buf_done` pulses with `buf_underrun`=1 and `halted` goes high.
- R5: `tx_err_irq` pulses in the same cycle as the underrun close, only if `irq_enable` was high in the underrun cycle.
- R6: At underrun the queue is emptied, including any byte accepted on that same edge. After the restart, `tx_valid` stays low until a new byte is written.
- R7: While `halted` is high, `wr_ready` and `tx_valid` are both low, and `halted` stays high until a restart.
- R8: `restart` while halted clears `halted` and `buf_underrun` on the next cycle. `restart` while not halted has no effect on the queue or the outputs.
- R9: Transfer of a byte with `tx_eof`=1 gives a `buf_done` pulse on the next cycle with `buf_underrun`=0 and no interrupt.
- R10: After reset, `wr_ready`=1, and `tx_valid`, `halted`, `buf_done`, `buf_underrun` and `tx_err_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Fetch side offers a byte |
| wr_ready | output | 1 | Queue accepts a byte this cycle |
| wr_byte | input | DATA_W | Byte offered by the fetch side |
| wr_eof | input | 1 | Offered byte ends its frame |
| tx_valid | output | 1 | A byte is available to the transmitter |
| tx_ready | input | 1 | Transmitter needs a byte this cycle |
| tx_byte | output | DATA_W | Byte at the head of the queue |
| tx_eof | output | 1 | Head byte ends its frame |
| restart | input | 1 | Restart-transmit command pulse |
| irq_enable | input | 1 | Enables the transmit-error interrupt |
| buf_done | output | 1 | One-cycle pulse: buffer closed |
| buf_underrun | output | 1 | Status of the last closed buffer: 1 if it was closed by underrun |
| tx_err_irq | output | 1 | One-cycle transmit-error interrupt |
| halted | output | 1 | Transmission locked out after underrun |

## Verification
The case that needs the most care is an underrun detected on the same edge on which the fetch side finally delivers a byte. The write is accepted by the handshake, but the flush takes priority and the byte must never reach the transmitter. The bench provokes this by sending one opening byte to a transmitter that is always ready. It then offers the next byte exactly in the cycle after the opening byte leaves, when the queue is empty. The bench judges the result in two ways. The scoreboard must never see the late byte, even after the restart. The status pins must show an underrun close and a halt.

// File: rtl/txq_abort_pkg.sv
package txq_abort_pkg;

  // Frame tracking state of the transmit side
  typedef enum logic [1:0] {
    TXQ_IDLE = 2'd0,   // between frames
    TXQ_OPEN = 2'd1,   // a frame is in flight
    TXQ_HALT = 2'd2    // locked out after underrun
  } txq_state_e;

endpackage

// File: rtl/txq_ring.sv
module txq_ring #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_nxt;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // One register per slot, written when the write pointer selects it
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (push && wr_ptr == PW'(i))
        slot[i] <= wdata;
    end
  end

  always_comb begin
    count_nxt = count;
    if (push) count_nxt = count_nxt + CW'(1);
    if (pop)  count_nxt = count_nxt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      // flush wins over a push on the same edge
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      count <= count_nxt;
    end
  end

  assign rdata = slot[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/txq_abort_ctrl.sv
module txq_abort_ctrl
  import txq_abort_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_fire,
  input  logic tx_fire_eof,
  input  logic tx_ready,
  input  logic q_empty,
  input  logic restart,
  input  logic irq_enable,
  output logic halted,
  output logic flush,
  output logic buf_done,
  output logic buf_underrun,
  output logic tx_err_irq
);

  txq_state_e state, state_nxt;
  logic underrun;
  logic clean_end;

  // Transmitter wants a byte mid-frame and nothing is queued
  assign underrun  = (state == TXQ_OPEN) && tx_ready && q_empty;
  assign clean_end = tx_fire && tx_fire_eof;
  assign flush     = underrun;
  assign halted    = (state == TXQ_HALT);

  always_comb begin
    state_nxt = state;
    unique case (state)
      TXQ_IDLE: if (tx_fire && !tx_fire_eof) state_nxt = TXQ_OPEN;
      TXQ_OPEN: begin
        if (underrun)       state_nxt = TXQ_HALT;
        else if (clean_end) state_nxt = TXQ_IDLE;
      end
      TXQ_HALT: if (restart) state_nxt = TXQ_IDLE;
      default:  state_nxt = TXQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= TXQ_IDLE;
      buf_done     <= 1'b0;
      buf_underrun <= 1'b0;
      tx_err_irq   <= 1'b0;
    end else begin
      state      <= state_nxt;
      buf_done   <= underrun || clean_end;
      tx_err_irq <= underrun && irq_enable;
      if (underrun)
        buf_underrun <= 1'b1;
      else if (clean_end || (halted && restart))
        buf_underrun <= 1'b0;
    end
  end

  p_halt_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> halted);
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && restart) |=> (!halted && !buf_underrun));
  p_underrun_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> (buf_done && buf_underrun && halted));
  p_irq_only_with_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_irq |-> (buf_done && buf_underrun));
  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_irq |-> $past(irq_enable));
  p_clean_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clean_end |=> (buf_done && !buf_underrun && !tx_err_irq));
  p_idle_no_error_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TXQ_IDLE && !tx_fire) |=> !buf_done);

endmodule

// File: rtl/txq_abort_top.sv
module txq_abort_top #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              wr_eof,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_eof,
  input  logic              restart,
  input  logic              irq_enable,
  output logic              buf_done,
  output logic              buf_underrun,
  output logic              tx_err_irq,
  output logic              halted
);

  localparam int EW = DATA_W + 1;

  logic          q_push, q_pop, q_flush, q_empty, q_full;
  logic [EW-1:0] q_rdata;
  logic          tx_fire;

  assign wr_ready = !q_full && !halted;
  assign q_push   = wr_valid && wr_ready;
  assign tx_valid = !q_empty && !halted;
  assign tx_fire  = tx_valid && tx_ready;
  assign q_pop    = tx_fire;
  assign tx_byte  = q_rdata[DATA_W-1:0];
  assign tx_eof   = q_rdata[DATA_W];

  txq_ring #(.WIDTH(EW), .DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .wdata ({wr_eof, wr_byte}),
    .pop   (q_pop),
    .flush (q_flush),
    .rdata (q_rdata),
    .empty (q_empty),
    .full  (q_full)
  );

  txq_abort_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_fire      (tx_fire),
    .tx_fire_eof  (tx_eof),
    .tx_ready     (tx_ready),
    .q_empty      (q_empty),
    .restart      (restart),
    .irq_enable   (irq_enable),
    .halted       (halted),
    .flush        (q_flush),
    .buf_done     (buf_done),
    .buf_underrun (buf_underrun),
    .tx_err_irq   (tx_err_irq)
  );

  p_halt_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!wr_ready && !tx_valid));
  p_head_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !restart) |=> (tx_valid && $stable(tx_byte) && $stable(tx_eof)));

endmodule

// File: tb/txq_abort_top_tb.sv
module txq_abort_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_eof = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       tx_ready = 1'b0, restart = 1'b0, irq_enable = 1'b0;
  logic       wr_ready, tx_valid, tx_eof, buf_done, buf_underrun, tx_err_irq, halted;
  logic [7:0] tx_byte;

  int checks = 0, errors = 0;
  int close_cnt = 0, irq_cnt = 0;
  logic last_un = 1'b0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_abort_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte), .wr_eof(wr_eof),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_eof(tx_eof),
    .restart(restart), .irq_enable(irq_enable),
    .buf_done(buf_done), .buf_underrun(buf_underrun), .tx_err_irq(tx_err_irq),
    .halted(halted)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Driver: offers one byte, records it as expected once the handshake is seen
  task automatic write_byte(input logic [7:0] d, input logic l);
    wr_valid = 1'b1; wr_byte = d; wr_eof = l;
    do @(negedge clk); while (!wr_ready);
    exp_q.push_back({l, d});
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic pulse_restart();
    restart = 1'b1; tick(); restart = 1'b0;
  endtask

  // Monitor: scoreboard compare and close/interrupt bookkeeping
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R6 byte reached transmitter with nothing expected", int'({tx_eof, tx_byte}), -1);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({tx_eof, tx_byte} == e, "R1 order and eof flag", int'({tx_eof, tx_byte}), int'(e));
        end
      end
      if (buf_done) begin close_cnt++; last_un = buf_underrun; end
      if (tx_err_irq) irq_cnt++;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    check(wr_ready == 1'b1, "R10 wr_ready", wr_ready, 1);
    check(tx_valid == 1'b0, "R10 tx_valid", tx_valid, 0);
    check(halted == 1'b0 && buf_done == 1'b0, "R10 halted/buf_done", {halted, buf_done}, 0);
    check(buf_underrun == 1'b0 && tx_err_irq == 1'b0, "R10 status", {buf_underrun, tx_err_irq}, 0);

    // R1 fill to depth, then drain as one frame
    tx_ready = 1'b0;
    write_byte(8'h11, 1'b0);
    write_byte(8'h22, 1'b0);
    write_byte(8'h33, 1'b1);
    check(wr_ready == 1'b0, "R1 full blocks writes", wr_ready, 0);
    check(tx_valid == 1'b1, "R2 valid when non-empty", tx_valid, 1);
    tx_ready = 1'b1;
    repeat (6) tick();
    // R9 clean close
    check(close_cnt == 1, "R9 close count", close_cnt, 1);
    check(last_un == 1'b0, "R9 close without underrun", last_un, 0);
    check(irq_cnt == 0, "R9 no interrupt", irq_cnt, 0);

    // R3 idle empty queue with a ready transmitter is not an error
    repeat (6) tick();
    check(close_cnt == 1 && halted == 1'b0, "R3 idle not underrun", close_cnt, 1);

    // R2 continuous stream with simultaneous write and read
    write_byte(8'hA1, 1'b0);
    write_byte(8'hA2, 1'b0);
    write_byte(8'hA3, 1'b0);
    write_byte(8'hA4, 1'b0);
    write_byte(8'hA5, 1'b1);
    repeat (6) tick();
    check(close_cnt == 2 && last_un == 1'b0, "R2 stream closes cleanly", close_cnt, 2);
    check(halted == 1'b0, "R2 no underrun while streaming", halted, 0);

    // R4 R5 underrun with interrupt enabled
    irq_enable = 1'b1;
    write_byte(8'h55, 1'b0);
    repeat (4) tick();
    check(close_cnt == 3, "R4 underrun closes buffer", close_cnt, 3);
    check(last_un == 1'b1, "R4 underrun status bit", last_un, 1);
    check(irq_cnt == 1, "R5 interrupt when enabled", irq_cnt, 1);
    check(halted == 1'b1, "R4 halted after underrun", halted, 1);
    // R7 lockout
    wr_valid = 1'b1; wr_byte = 8'h66; wr_eof = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(wr_ready == 1'b0 && tx_valid == 1'b0, "R7 halted refuses traffic", {wr_ready, tx_valid}, 0);
      check(halted == 1'b1, "R7 halt persists", halted, 1);
    end
    wr_valid = 1'b0;
    // R8 restart
    pulse_restart();
    check(halted == 1'b0 && buf_underrun == 1'b0, "R8 restart clears", {halted, buf_underrun}, 0);
    check(wr_ready == 1'b1, "R8 writes accepted again", wr_ready, 1);
    check(tx_valid == 1'b0, "R6 queue empty after restart", tx_valid, 0);

    // R5 underrun with interrupt disabled
    irq_enable = 1'b0;
    write_byte(8'h77, 1'b0);
    repeat (4) tick();
    check(close_cnt == 4 && last_un == 1'b1, "R5 underrun close without irq", close_cnt, 4);
    check(irq_cnt == 1, "R5 no interrupt when disabled", irq_cnt, 1);
    pulse_restart();

    // R6 write accepted on the underrun edge is discarded
    irq_enable = 1'b1;
    wr_valid = 1'b1; wr_byte = 8'h88; wr_eof = 1'b0;
    @(negedge clk);
    exp_q.push_back({1'b0, 8'h88});
    tick();                     // 0x88 enters queue
    wr_valid = 1'b0;
    tick();                     // 0x88 leaves, frame open, queue empty
    wr_valid = 1'b1; wr_byte = 8'h99; wr_eof = 1'b1;
    @(negedge clk);
    check(wr_ready == 1'b1, "R6 late write is accepted", wr_ready, 1);
    tick();                     // underrun edge, 0x99 accepted and flushed
    wr_valid = 1'b0;
    repeat (2) tick();
    check(halted == 1'b1 && close_cnt == 5, "R6 underrun on write edge", close_cnt, 5);
    check(irq_cnt == 2, "R5 interrupt on write edge", irq_cnt, 2);
    pulse_restart();
    repeat (3) tick();
    check(tx_valid == 1'b0, "R6 flushed byte not delivered", tx_valid, 0);

    // R8 restart while running is ignored
    tx_ready = 1'b0;
    write_byte(8'hAA, 1'b1);
    pulse_restart();
    check(halted == 1'b0 && tx_valid == 1'b1, "R8 idle restart keeps queue", {halted, tx_valid}, 2'b01);
    tx_ready = 1'b1;
    repeat (4) tick();
    check(close_cnt == 6 && last_un == 1'b0, "R8 byte delivered after idle restart", close_cnt, 6);

    // R3 single-byte frames never open a frame
    tx_ready = 1'b0;
    write_byte(8'hC1, 1'b1);
    write_byte(8'hC2, 1'b1);
    write_byte(8'hC3, 1'b1);
    tx_ready = 1'b1;
    repeat (6) tick();
    check(close_cnt == 9 && halted == 1'b0, "R3 single-byte frames", close_cnt, 9);
    check(irq_cnt == 2 && last_un == 1'b0, "R9 no error on single-byte frames", irq_cnt, 2);

    check(exp_q.size() == 0, "R1 all expected bytes delivered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule